// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Register

This block collects the event pulses produced by two timer/counter cores, a 16-bit one and an 8-bit one, and keeps each event as a sticky flag in an 8-bit flag register. The events are input capture (or TOP reached, when the capture register sets the period), compare match A and B on each timer, and overflow on each timer. An 8-bit enable register sits beside the flag register with the same bit positions. Each source raises its interrupt request line only while its flag is set, its enable bit is set and the global interrupt enable is high.

Software clears a flag by writing a one to its bit position. Writing a zero leaves the bit alone. The interrupt controller can also clear a flag by acknowledging the matching vector on a one-hot acknowledge input. Compare matches are not raised straight away. They are held for one timer clock tick, counted by a timer clock enable, and a match that arrives together with a forced-compare strobe is discarded.

Top module: `tmr_irq_flags`

## Requirements
- R1: While reset is asserted, and after it is released, every flag bit, every enable bit and every interrupt request is 0.
- R2: Bit 6 of the flag register and bit 6 of the enable register always read 0, whatever is written to them or acknowledged.
- R3: A flag-register write clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R4: The acknowledge input is one-hot, with the same bit positions as the flag register, and clears only the flag at the acknowledged position.
- R5: A compare match seen on a timer tick sets its flag on the next timer tick, not earlier. Cycles without a tick do not advance the delay. Compare flag positions are bit 1 for A0, bit 2 for B0, bit 4 for A1 and bit 5 for B1. On the match and force inputs, index 0 is A0, index 1 is B0, index 2 is A1 and index 3 is B1.
- R6: A compare match that arrives on a tick together with the forced-compare strobe of the same index never sets a flag.
- R7: Flag bit 7 sets on a capture event while capture-as-TOP is 0, and on a TOP-reached event while capture-as-TOP is 1. The event not selected is ignored.
- R8: The overflow flags (bit 0 for the 8-bit timer on index 0, bit 3 for the 16-bit timer on index 1) set from the wrap event when the mode-event select bit of that index is 0, and from the mode-dependent event when the select bit is 1. The event not selected is ignored.
- R9: irqReq[i] is 1 exactly when flag i is 1, enable i is 1 and globalIe is 1.
- R10: When a set event and a clear, by write or by acknowledge, hit the same flag in the same cycle, the flag ends up set.
- R11: An enable-register write loads the write data into the enable register, and the new value is readable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrTick | input | 1 | Timer clock enable |
| cmpMatch | input | 4 | Counter equals compare register (A0, B0, A1, B1) |
| forceCmp | input | 4 | Forced-compare strobes, same indexing |
| captureEvt | input | 1 | Capture event at the capture pin |
| topHitEvt | input | 1 | Counter reached TOP |
| capIsTop | input | 1 | Capture register is the TOP source |
| ovfWrap | input | 2 | Counter wrap event (index 0: 8-bit, 1: 16-bit) |
| ovfModeEvt | input | 2 | Mode-dependent overflow set point |
| ovfUseModeEvt | input | 2 | Select the mode-dependent set point |
| busWrFlag | input | 1 | Write strobe for the flag register |
| busWrEn | input | 1 | Write strobe for the enable register |
| busWrData | input | 8 | Write data |
| ack | input | 8 | One-hot vector acknowledge |
| globalIe | input | 1 | Global interrupt enable |
| flagRd | output | 8 | Flag register value |
| enableRd | output | 8 | Enable register value |
| irqReq | output | 8 | Per-source interrupt requests |

## Verification
The bench targets the compare delay. It applies a match on one tick, then holds several cycles without a tick: a design that counted system clocks, or set the flag at the match, would show the flag too early. It drives a match and a force strobe together, which a design that ignored the strobe would turn into a flag. It makes a set and a write-one-clear collide, where a clear-first design would lose the event. It writes ones to bit 6 and checks that a writable reserved bit shows up. A long randomized phase then compares every output against a behavioural model on every cycle. This catches acknowledges that clear the wrong bit, wrong event selection for capture or overflow, and interrupt requests that leak while globalIe is low.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int REG_W    = 8;
  localparam int CMP_N    = 4;
  localparam int TMR_N    = 2;
  localparam int BIT_OVF0 = 0;
  localparam int BIT_OVF1 = 3;
  localparam int BIT_RSVD = 6;
  localparam int BIT_CAP  = 7;
  localparam logic [REG_W-1:0] LIVE_MASK = ~(REG_W'(1) << BIT_RSVD);

  typedef struct packed {
    logic [REG_W-1:0] setVec;
    logic [REG_W-1:0] clrVec;
    logic             enLoad;
    logic [REG_W-1:0] enData;
  } flagStrobes_t;

  // compare index 0..3 (A0,B0,A1,B1) to flag bit position 1,2,4,5
  function automatic int cmpBit(input int idx);
    return (idx < 2) ? idx + 1 : idx + 2;
  endfunction

  function automatic int ovfBit(input int tmr);
    return (tmr == 0) ? BIT_OVF0 : BIT_OVF1;
  endfunction
endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrTick,
  input  logic [CMP_N-1:0]  cmpMatch,
  input  logic [CMP_N-1:0]  forceCmp,
  input  logic              captureEvt,
  input  logic              topHitEvt,
  input  logic              capIsTop,
  input  logic [TMR_N-1:0]  ovfWrap,
  input  logic [TMR_N-1:0]  ovfModeEvt,
  input  logic [TMR_N-1:0]  ovfUseModeEvt,
  input  logic              busWrFlag,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  input  logic [REG_W-1:0]  ack,
  output flagStrobes_t      strb
);
  logic [CMP_N-1:0] cmpPend;

  // one-tick hold of a qualified compare match
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cmpPend <= '0;
    else if (tmrTick) cmpPend <= cmpMatch & ~forceCmp;
  end

  always_comb begin
    strb.setVec = '0;
    for (int i = 0; i < CMP_N; i++)
      strb.setVec[cmpBit(i)] = tmrTick & cmpPend[i];
    for (int t = 0; t < TMR_N; t++)
      strb.setVec[ovfBit(t)] = ovfUseModeEvt[t] ? ovfModeEvt[t] : ovfWrap[t];
    strb.setVec[BIT_CAP] = capIsTop ? topHitEvt : captureEvt;
    strb.clrVec = (busWrFlag ? busWrData : '0) | ack;
    strb.enLoad = busWrEn;
    strb.enData = busWrData;
  end
endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobes_t     strb,
  input  logic             globalIe,
  output logic [REG_W-1:0] flagRd,
  output logic [REG_W-1:0] enableRd,
  output logic [REG_W-1:0] irqReq
);
  logic [REG_W-1:0] flagQ, enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
    end else begin
      // set is applied after clear so a coincident event survives
      flagQ <= ((flagQ & ~strb.clrVec) | strb.setVec) & LIVE_MASK;
      if (strb.enLoad) enQ <= strb.enData & LIVE_MASK;
    end
  end

  assign flagRd   = flagQ;
  assign enableRd = enQ;
  assign irqReq   = flagQ & enQ & {REG_W{globalIe}};
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tmrTick,
  input  logic [3:0]       cmpMatch,
  input  logic [3:0]       forceCmp,
  input  logic             captureEvt,
  input  logic             topHitEvt,
  input  logic             capIsTop,
  input  logic [1:0]       ovfWrap,
  input  logic [1:0]       ovfModeEvt,
  input  logic [1:0]       ovfUseModeEvt,
  input  logic             busWrFlag,
  input  logic             busWrEn,
  input  logic [7:0]       busWrData,
  input  logic [7:0]       ack,
  input  logic             globalIe,
  output logic [7:0]       flagRd,
  output logic [7:0]       enableRd,
  output logic [7:0]       irqReq
);
  flagStrobes_t strb;

  tmr_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tmrTick(tmrTick),
    .cmpMatch(cmpMatch), .forceCmp(forceCmp),
    .captureEvt(captureEvt), .topHitEvt(topHitEvt), .capIsTop(capIsTop),
    .ovfWrap(ovfWrap), .ovfModeEvt(ovfModeEvt), .ovfUseModeEvt(ovfUseModeEvt),
    .busWrFlag(busWrFlag), .busWrEn(busWrEn), .busWrData(busWrData),
    .ack(ack), .strb(strb)
  );

  tmr_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .globalIe(globalIe),
    .flagRd(flagRd), .enableRd(enableRd), .irqReq(irqReq)
  );
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tmrTick,
  input logic       captureEvt,
  input logic       capIsTop,
  input logic [1:0] ovfWrap,
  input logic [1:0] ovfModeEvt,
  input logic [1:0] ovfUseModeEvt,
  input logic       busWrFlag,
  input logic [7:0] busWrData,
  input logic [7:0] ack,
  input logic       globalIe,
  input logic [7:0] flagRd,
  input logic [7:0] enableRd,
  input logic [7:0] irqReq
);
  always_comb begin
    if (!rstN) p_reset_clear_r1 : assert (flagRd == 8'h00 && enableRd == 8'h00);
  end

  p_rsvd_zero_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (flagRd[6] == 1'b0) && (enableRd[6] == 1'b0));

  p_ack_clears_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (ack == 8'h01 && !ovfWrap[0] && !ovfModeEvt[0]) |=> !flagRd[0]);

  p_cmp_waits_tick_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (!tmrTick && !flagRd[1]) |=> !flagRd[1]);

  p_capture_sets_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (!capIsTop && captureEvt) |=> flagRd[7]);

  p_no_irq_masked_r9 : assert property (@(posedge clk) disable iff (!rstN)
    !globalIe |-> (irqReq == 8'h00));

  p_set_beats_clear_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (busWrFlag && busWrData[0] && ovfWrap[0] && !ovfUseModeEvt[0]) |=> flagRd[0]);
endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .captureEvt(captureEvt),
  .capIsTop(capIsTop), .ovfWrap(ovfWrap), .ovfModeEvt(ovfModeEvt),
  .ovfUseModeEvt(ovfUseModeEvt), .busWrFlag(busWrFlag), .busWrData(busWrData),
  .ack(ack), .globalIe(globalIe), .flagRd(flagRd), .enableRd(enableRd),
  .irqReq(irqReq)
);

// File: tb/tmr_irq_flags_bench.sv
module tmr_irq_flags_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 0, rstN = 0;
  logic tmrTick, captureEvt, topHitEvt, capIsTop, busWrFlag, busWrEn, globalIe;
  logic [3:0] cmpMatch, forceCmp;
  logic [1:0] ovfWrap, ovfModeEvt, ovfUseModeEvt;
  logic [7:0] busWrData, ack, flagRd, enableRd, irqReq;

  int nVec = 0, nBad = 0;
  string curReq = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_flags u_tmr_irq_flags (.*);

  // behavioural reference model
  bit [7:0] mFlag, mEn;
  bit [3:0] mPend;
  int cmpPos [4] = '{1, 2, 4, 5};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFlag = 0; mEn = 0; mPend = 0;
    end else begin
      bit [7:0] s, c;
      s = 0;
      for (int i = 0; i < 4; i++) if (tmrTick && mPend[i]) s[cmpPos[i]] = 1;
      s[0] = ovfUseModeEvt[0] ? ovfModeEvt[0] : ovfWrap[0];
      s[3] = ovfUseModeEvt[1] ? ovfModeEvt[1] : ovfWrap[1];
      s[7] = capIsTop ? topHitEvt : captureEvt;
      c = ack | (busWrFlag ? busWrData : 8'h00);
      mFlag = ((mFlag & ~c) | s) & 8'hBF;
      if (busWrEn) mEn = busWrData & 8'hBF;
      if (tmrTick) mPend = cmpMatch & ~forceCmp;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    tmrTick = 0; cmpMatch = 0; forceCmp = 0; captureEvt = 0; topHitEvt = 0;
    ovfWrap = 0; ovfModeEvt = 0; busWrFlag = 0; busWrEn = 0; busWrData = 0;
    ack = 0;
  endtask

  // advance one clock, then compare against the model at the falling edge
  task automatic cyc();
    @(posedge clk); @(negedge clk);
    chk(curReq, "flagRd", flagRd, mFlag);
    chk(curReq, "enableRd", enableRd, mEn);
    chk(curReq, "irqReq", irqReq, mFlag & mEn & {8{globalIe}});
    idle();
  endtask

  task automatic wrFlag(logic [7:0] d);
    busWrFlag = 1; busWrData = d; cyc();
  endtask

  initial begin
    idle(); capIsTop = 0; ovfUseModeEvt = 0; globalIe = 0;
    repeat (2) @(negedge clk);
    chk("R1", "flagRd in reset", flagRd, 8'h00);
    chk("R1", "enableRd in reset", enableRd, 8'h00);
    chk("R1", "irqReq in reset", irqReq, 8'h00);
    rstN = 1;
    cyc();
    chk("R1", "flagRd after reset", flagRd, 8'h00);

    curReq = "R11";
    busWrEn = 1; busWrData = 8'hFF; cyc();
    chk("R11", "enable load", enableRd, 8'hBF);
    chk("R2", "enable bit6", enableRd[6], 1'b0);

    curReq = "R7";
    captureEvt = 1; cyc();
    chk("R7", "capture sets", flagRd[7], 1'b1);
    wrFlag(8'h80);
    capIsTop = 1; captureEvt = 1; cyc();
    chk("R7", "capture ignored when TOP", flagRd[7], 1'b0);
    topHitEvt = 1; cyc();
    chk("R7", "TOP hit sets", flagRd[7], 1'b1);
    capIsTop = 0;

    curReq = "R8";
    ovfWrap = 2'b01; cyc();
    chk("R8", "wrap sets ovf0", flagRd[0], 1'b1);
    wrFlag(8'h01);
    ovfUseModeEvt = 2'b11; ovfWrap = 2'b11; cyc();
    chk("R8", "wrap ignored in mode", flagRd & 8'h09, 8'h00);
    ovfModeEvt = 2'b10; cyc();
    chk("R8", "mode event sets ovf1", flagRd & 8'h09, 8'h08);
    ovfUseModeEvt = 0;

    curReq = "R3";
    ovfWrap = 2'b01; cyc();
    wrFlag(8'h00);
    chk("R3", "write zero keeps", flagRd, 8'h89);
    wrFlag(8'h01);
    chk("R3", "write one clears bit0 only", flagRd, 8'h88);

    curReq = "R4";
    ack = 8'h08; cyc();
    chk("R4", "ack clears bit3 only", flagRd, 8'h80);

    curReq = "R5";
    tmrTick = 1; cmpMatch = 4'b0001; cyc();
    chk("R5", "no flag at match", flagRd[1], 1'b0);
    repeat (3) cyc();
    chk("R5", "no flag without tick", flagRd[1], 1'b0);
    tmrTick = 1; cyc();
    chk("R5", "flag on next tick", flagRd[1], 1'b1);
    tmrTick = 1; cmpMatch = 4'b1000; cyc();
    tmrTick = 1; cyc();
    chk("R5", "B1 at bit5", flagRd[5], 1'b1);

    curReq = "R6";
    tmrTick = 1; cmpMatch = 4'b0010; forceCmp = 4'b0010; cyc();
    tmrTick = 1; cyc();
    tmrTick = 1; cyc();
    chk("R6", "forced match no flag", flagRd[2], 1'b0);

    curReq = "R10";
    wrFlag(8'hFF);
    busWrFlag = 1; busWrData = 8'h01; ovfWrap = 2'b01; cyc();
    chk("R10", "set beats write clear", flagRd[0], 1'b1);
    ack = 8'h80; captureEvt = 1; cyc();
    chk("R10", "set beats ack clear", flagRd[7], 1'b1);

    curReq = "R9";
    globalIe = 0; cyc();
    chk("R9", "masked by globalIe", irqReq, 8'h00);
    globalIe = 1; cyc();
    chk("R9", "irq follows flags", irqReq, 8'h81);
    busWrEn = 1; busWrData = 8'h01; cyc();
    chk("R9", "irq follows enables", irqReq, 8'h01);

    curReq = "R2";
    busWrFlag = 1; busWrData = 8'h40; ack = 8'h40; cyc();
    chk("R2", "flag bit6 zero", flagRd[6], 1'b0);

    curReq = "R9/R4/R3 random";
    for (int n = 0; n < 3000; n++) begin
      tmrTick = $urandom_range(0, 1); cmpMatch = 4'($urandom);
      forceCmp = 4'($urandom) & 4'($urandom);
      captureEvt = ($urandom_range(0, 7) == 0); topHitEvt = ($urandom_range(0, 7) == 0);
      capIsTop = $urandom_range(0, 1);
      ovfWrap = 2'($urandom) & 2'($urandom); ovfModeEvt = 2'($urandom) & 2'($urandom);
      ovfUseModeEvt = 2'($urandom);
      busWrFlag = ($urandom_range(0, 3) == 0); busWrEn = ($urandom_range(0, 7) == 0);
      busWrData = 8'($urandom);
      ack = ($urandom_range(0, 2) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      globalIe = $urandom_range(0, 1);
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule